// File: doc/BRIEF.md
# Voltage-Frequency Scaling Sequencer

This block moves a chip between operating points. Software names a target performance level. The block then steps two outputs, a clock-generator frequency code and a supply-regulator voltage code, to the matching pair. It orders the steps so that the clock never runs faster than the supply it has at that moment can carry. When the level goes up, the supply is raised first and the clock follows once the regulator reports that the new voltage has settled. When the level goes down, the clock is lowered first and the supply follows once the clock generator reports lock at the slower rate.

Each frequency setting is paired with the lowest voltage code that supports it. That table is built in hardware from the parameter widths and rises monotonically with frequency. A request that arrives while a transition is in progress is held and served after the transition ends. If the settle or lock report is missing for too long, the block raises an error flag.

Top module: `vf_step_seq`

## Requirements
- R1: After reset, freqCode is 0, voltCode is 0, busy is 0 and timeoutErr is 0.
- R2: When level L is reached, freqCode equals L. voltCode equals the minimum code for L, which is the smallest v with v*15 >= L*31 (for L = 0, 1, 2, 7, 15 this gives v = 0, 3, 5, 15, 31).
- R3: On a move up, voltCode changes before freqCode. freqCode rises only on a clock edge where voltStable is sampled high. The earliest such edge is the second edge after the voltage change.
- R4: On a move down, freqCode changes before voltCode. voltCode falls only on a clock edge where pllLock is sampled high. The earliest such edge is the second edge after the frequency change.
- R5: At every cycle, voltCode is at least the minimum code (R2) for the current freqCode.
- R6: A reqLevel above 15 is treated as 15.
- R7: A request that arrives during a transition is held and acted on after the transition ends. If several requests arrive before it is served, the most recent one wins.
- R8: busy is high from the cycle after reqValid until the codes match the target. A request for the current level leaves both codes unchanged, and busy falls within three cycles.
- R9: If the awaited handshake stays low for TMO_LIM cycles in a wait, timeoutErr rises. The transition still completes when the handshake arrives. The flag clears when the next request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | One-cycle strobe carrying a new target level |
| reqLevel | input | REQ_W | Requested level, saturated to the top level |
| voltStable | input | 1 | Regulator reports the supply has settled (level) |
| pllLock | input | 1 | Clock generator reports lock (level) |
| freqCode | output | FREQ_W | Frequency setting to the clock generator |
| voltCode | output | VOLT_W | Voltage setting to the regulator |
| busy | output | 1 | A request is pending or a transition is in progress |
| timeoutErr | output | 1 | A handshake wait exceeded the limit |

## Verification
The bench builds the block with the default code widths: 16 frequency settings, 32 voltage codes and a 5-bit request. At these widths every table entry and request saturation is reachable. The timeout limit is cut to 40 cycles, so a hung regulator trips the error flag and the run can recover within a short test. The regulator and clock-generator models have adjustable delays. Long delays expose the ordering windows in both directions and the queuing of a request made during a transition.

// File: rtl/vfs_pkg.sv
package vfs_pkg;

  typedef struct packed {
    logic takeReq;
    logic setVolt;
    logic setFreq;
    logic cntClr;
    logic cntRun;
  } vfsStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_DECIDE, S_UP_GAP, S_UP_WAIT, S_DN_GAP, S_DN_WAIT
  } vfsState_t;

  // ceil(f * vMax / fMax): lowest voltage code able to carry frequency code f
  function automatic int unsigned minVoltOf(int unsigned f, int unsigned fMax,
                                            int unsigned vMax);
    return (f * vMax + fMax - 1) / fMax;
  endfunction

endpackage

// File: rtl/vfs_path.sv
module vfs_path
  import vfs_pkg::*;
#(
  parameter int FREQ_W  = 4,
  parameter int VOLT_W  = 5,
  parameter int REQ_W   = 5,
  parameter int TMO_LIM = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [REQ_W-1:0]  reqLevel,
  input  vfsStrobe_t        stb,
  output logic [FREQ_W-1:0] freqCode,
  output logic [VOLT_W-1:0] voltCode,
  output logic              timeoutErr,
  output logic              pendValid,
  output logic              tgtAbove,
  output logic              tgtBelow
);
  localparam int FLVLS = 2 ** FREQ_W;
  localparam int FMAX  = FLVLS - 1;
  localparam int VMAX  = 2 ** VOLT_W - 1;
  localparam int CNT_W = $clog2(TMO_LIM + 1);

  logic [VOLT_W-1:0] vminTab [FLVLS];
  logic [FREQ_W-1:0] pendLvl, tgtLvl, reqSat;
  logic [CNT_W-1:0]  waitCnt;

  for (genvar g = 0; g < FLVLS; g++) begin : g_vmin
    assign vminTab[g] = VOLT_W'(minVoltOf(g, FMAX, VMAX));
  end

  assign reqSat   = (reqLevel > REQ_W'(FMAX)) ? FREQ_W'(FMAX) : reqLevel[FREQ_W-1:0];
  assign tgtAbove = tgtLvl > freqCode;
  assign tgtBelow = tgtLvl < freqCode;

  // request holding register: the newest request always overwrites
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendLvl   <= '0;
    end else if (reqValid) begin
      pendValid <= 1'b1;
      pendLvl   <= reqSat;
    end else if (stb.takeReq) begin
      pendValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtLvl   <= '0;
      freqCode <= '0;
      voltCode <= '0;
    end else begin
      if (stb.takeReq) tgtLvl   <= pendLvl;
      if (stb.setFreq) freqCode <= tgtLvl;
      if (stb.setVolt) voltCode <= vminTab[tgtLvl];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt    <= '0;
      timeoutErr <= 1'b0;
    end else begin
      if (stb.cntClr)
        waitCnt <= '0;
      else if (stb.cntRun && waitCnt != CNT_W'(TMO_LIM))
        waitCnt <= waitCnt + 1'b1;
      if (stb.takeReq)
        timeoutErr <= 1'b0;
      else if (stb.cntRun && waitCnt == CNT_W'(TMO_LIM))
        timeoutErr <= 1'b1;
    end
  end

endmodule

// File: rtl/vfs_ctrl.sv
module vfs_ctrl
  import vfs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pendValid,
  input  logic       tgtAbove,
  input  logic       tgtBelow,
  input  logic       voltStable,
  input  logic       pllLock,
  output vfsStrobe_t stb,
  output logic       busy
);
  vfsState_t state, stateNxt;

  always_comb begin
    stb      = '0;
    stateNxt = state;
    unique case (state)
      S_IDLE: if (pendValid) begin
        stb.takeReq = 1'b1;
        stateNxt    = S_DECIDE;
      end
      S_DECIDE: begin
        if (tgtAbove) begin
          stb.setVolt = 1'b1;
          stateNxt    = S_UP_GAP;
        end else if (tgtBelow) begin
          stb.setFreq = 1'b1;
          stateNxt    = S_DN_GAP;
        end else begin
          stateNxt = S_IDLE;
        end
      end
      // one cycle for the regulator or PLL to drop its stale report
      S_UP_GAP: begin
        stb.cntClr = 1'b1;
        stateNxt   = S_UP_WAIT;
      end
      S_UP_WAIT: begin
        if (voltStable) begin
          stb.setFreq = 1'b1;
          stateNxt    = S_IDLE;
        end else begin
          stb.cntRun = 1'b1;
        end
      end
      S_DN_GAP: begin
        stb.cntClr = 1'b1;
        stateNxt   = S_DN_WAIT;
      end
      S_DN_WAIT: begin
        if (pllLock) begin
          stb.setVolt = 1'b1;
          stateNxt    = S_IDLE;
        end else begin
          stb.cntRun = 1'b1;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  assign busy = (state != S_IDLE) || pendValid;

endmodule

// File: rtl/vf_step_seq.sv
module vf_step_seq
  import vfs_pkg::*;
#(
  parameter int FREQ_W  = 4,
  parameter int VOLT_W  = 5,
  parameter int REQ_W   = 5,
  parameter int TMO_LIM = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [REQ_W-1:0]  reqLevel,
  input  logic              voltStable,
  input  logic              pllLock,
  output logic [FREQ_W-1:0] freqCode,
  output logic [VOLT_W-1:0] voltCode,
  output logic              busy,
  output logic              timeoutErr
);
  vfsStrobe_t stb;
  logic pendValid, tgtAbove, tgtBelow;

  vfs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pendValid(pendValid), .tgtAbove(tgtAbove),
    .tgtBelow(tgtBelow), .voltStable(voltStable), .pllLock(pllLock),
    .stb(stb), .busy(busy)
  );

  vfs_path #(.FREQ_W(FREQ_W), .VOLT_W(VOLT_W), .REQ_W(REQ_W), .TMO_LIM(TMO_LIM)) u_path (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLevel(reqLevel), .stb(stb),
    .freqCode(freqCode), .voltCode(voltCode), .timeoutErr(timeoutErr),
    .pendValid(pendValid), .tgtAbove(tgtAbove), .tgtBelow(tgtBelow)
  );

endmodule

// File: rtl/vfs_chk.sv
module vfs_chk
  import vfs_pkg::*;
#(
  parameter int FREQ_W = 4,
  parameter int VOLT_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [FREQ_W-1:0] freqCode,
  input logic [VOLT_W-1:0] voltCode,
  input logic              voltStable,
  input logic              pllLock,
  input logic              busy,
  input logic              timeoutErr
);
  localparam int FMAX = 2 ** FREQ_W - 1;
  localparam int VMAX = 2 ** VOLT_W - 1;

  a_r5_volt_covers_freq: assert property (@(posedge clk) disable iff (!rstN)
    int'(voltCode) >= minVoltOf(int'(freqCode), FMAX, VMAX));

  a_r3_rise_needs_stable: assert property (@(posedge clk) disable iff (!rstN)
    (freqCode > $past(freqCode)) |-> $past(voltStable));

  a_r4_drop_needs_lock: assert property (@(posedge clk) disable iff (!rstN)
    (voltCode < $past(voltCode)) |-> $past(pllLock));

  a_r3_one_code_per_edge: assert property (@(posedge clk) disable iff (!rstN)
    (freqCode != $past(freqCode)) |-> (voltCode == $past(voltCode)));

  a_r8_change_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    ((freqCode != $past(freqCode)) || (voltCode != $past(voltCode))) |-> $past(busy));

  a_r9_flag_in_transition: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> busy);

endmodule

bind vf_step_seq vfs_chk #(.FREQ_W(FREQ_W), .VOLT_W(VOLT_W)) u_chk (
  .clk(clk), .rstN(rstN), .freqCode(freqCode), .voltCode(voltCode),
  .voltStable(voltStable), .pllLock(pllLock), .busy(busy), .timeoutErr(timeoutErr)
);

// File: tb/sim_vf_step_seq.sv
`timescale 1ns/100ps
module sim_vf_step_seq;
  localparam int FREQ_W = 4, VOLT_W = 5, REQ_W = 5, TMO_LIM = 40;
  localparam int FMAX = 15, VMAX = 31;
  localparam int NVEC = 10;
  // {requested level, expected frequency code}
  localparam logic [8:0] VEC [NVEC] = '{
    {5'd5, 4'd5}, {5'd12, 4'd12}, {5'd3, 4'd3}, {5'd0, 4'd0}, {5'd15, 4'd15},
    {5'd31, 4'd15}, {5'd7, 4'd7}, {5'd20, 4'd15}, {5'd1, 4'd1}, {5'd7, 4'd7}
  };

  logic clk = 0, rstN = 0, reqValid = 0, voltStable, pllLock;
  logic [REQ_W-1:0] reqLevel = '0;
  logic [FREQ_W-1:0] freqCode;
  logic [VOLT_W-1:0] voltCode;
  logic busy, timeoutErr;

  int nChk = 0, nBad = 0, safeBad = 0, cyc = 0;
  int regDly = 3, pllDly = 4;
  logic regHang = 0;
  logic [VOLT_W-1:0] seenV;
  logic [FREQ_W-1:0] seenF;
  int rCnt, pCnt;

  always #2.5 clk = ~clk;

  vf_step_seq #(.FREQ_W(FREQ_W), .VOLT_W(VOLT_W), .REQ_W(REQ_W), .TMO_LIM(TMO_LIM)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLevel(reqLevel),
    .voltStable(voltStable), .pllLock(pllLock), .freqCode(freqCode),
    .voltCode(voltCode), .busy(busy), .timeoutErr(timeoutErr)
  );

  // regulator and clock-generator models: drop the report on a code change, restore after a delay
  always @(posedge clk) begin
    if (!rstN) begin
      seenV <= '0; voltStable <= 1'b1; rCnt <= 0;
      seenF <= '0; pllLock <= 1'b1; pCnt <= 0;
    end else begin
      if (voltCode != seenV) begin seenV <= voltCode; voltStable <= 1'b0; rCnt <= regDly; end
      else if (rCnt != 0) rCnt <= rCnt - 1;
      else if (!regHang) voltStable <= 1'b1;
      if (freqCode != seenF) begin seenF <= freqCode; pllLock <= 1'b0; pCnt <= pllDly; end
      else if (pCnt != 0) pCnt <= pCnt - 1;
      else pllLock <= 1'b1;
    end
  end

  function automatic int vminRef(int f);
    int v = 0;
    while (v * FMAX < f * VMAX) v++;
    return v;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rstN && int'(voltCode) < vminRef(int'(freqCode))) safeBad++;
    if (cyc > 150000) begin
      nBad++;
      $display("FAIL watchdog: actual cycles %0d expected under 150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic issue(int lvl);
    @(negedge clk);
    reqValid = 1'b1; reqLevel = REQ_W'(lvl);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 2000) begin @(negedge clk); n++; end
    check("R8 busy clears", int'(busy), 0);
  endtask

  task automatic stepN(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    stepN(4);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 freq", int'(freqCode), 0);
    check("R1 volt", int'(voltCode), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 err", int'(timeoutErr), 0);

    // table walk: R2 and R6
    for (int k = 0; k < NVEC; k++) begin
      issue(int'(VEC[k][8:4]));
      check("R8 busy after request", int'(busy), 1);
      waitIdle();
      check("R2/R6 freq", int'(freqCode), int'(VEC[k][3:0]));
      check("R2 volt", int'(voltCode), vminRef(int'(VEC[k][3:0])));
    end

    // R8: request for the current level (7)
    issue(7);
    check("R8 busy on same level", int'(busy), 1);
    stepN(3);
    check("R8 same level busy low", int'(busy), 0);
    check("R8 same level freq", int'(freqCode), 7);
    check("R8 same level volt", int'(voltCode), 15);

    // R3: slow regulator, move up 7 -> 13
    regDly = 20;
    issue(13);
    begin
      int n = 0;
      while (int'(voltCode) == 15 && n < 20) begin @(negedge clk); n++; end
    end
    check("R3 volt raised", int'(voltCode), 27);
    check("R3 freq held at volt change", int'(freqCode), 7);
    stepN(10);
    check("R3 freq held while unsettled", int'(freqCode), 7);
    waitIdle();
    check("R3 freq final", int'(freqCode), 13);

    // R4: slow PLL, move down 13 -> 2
    pllDly = 20;
    issue(2);
    begin
      int n = 0;
      while (int'(freqCode) == 13 && n < 20) begin @(negedge clk); n++; end
    end
    check("R4 freq lowered", int'(freqCode), 2);
    check("R4 volt held at freq change", int'(voltCode), 27);
    stepN(10);
    check("R4 volt held while unlocked", int'(voltCode), 27);
    waitIdle();
    check("R4 volt final", int'(voltCode), 5);

    // R7: requests during a transition, the newest wins
    issue(14);
    stepN(5);
    issue(4);
    issue(6);
    check("R7 busy held", int'(busy), 1);
    waitIdle();
    check("R7 freq newest", int'(freqCode), 6);
    check("R7 volt newest", int'(voltCode), 13);

    // R9: regulator never settles
    regDly = 3; pllDly = 4;
    regHang = 1'b1;
    issue(9);
    stepN(20);
    check("R9 no early flag", int'(timeoutErr), 0);
    stepN(40);
    check("R9 flag raised", int'(timeoutErr), 1);
    check("R9/R3 freq held", int'(freqCode), 6);
    regHang = 1'b0;
    waitIdle();
    check("R9 completes late", int'(freqCode), 9);
    check("R9 flag kept", int'(timeoutErr), 1);
    issue(2);
    stepN(2);
    check("R9 flag cleared", int'(timeoutErr), 0);
    waitIdle();
    check("R9 next move", int'(voltCode), 5);

    check("R5 safety violations", safeBad, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule